// File: doc/BRIEF.md
# Test Register File with Pattern Engine

This block sits behind a simple register port (write strobe, read request, shared address, one-cycle read return) and serves two 256-byte address pages. The first page is forwarded to the register port of a TCP offload engine. The second page holds local control and status registers. A read of the first page returns whatever the engine presents for that offset.

The block also contains two traffic engines. The generator pushes incrementing 32-bit values, packed into wide words, into the engine's transmit FIFO. It holds back while that FIFO is full and stops after a programmed number of words. The checker drains the engine's receive FIFO whenever it is not empty. It counts the words it reads and, when verification is on, compares each word against the same incrementing pattern, setting a sticky error flag on any mismatch.

Software starts a transfer by writing zero to bit 0 of the command register. It then polls the busy bit, the word counts and the error bit.

Top module: `tpe_regfile`

## Requirements
- R1: Byte addresses whose upper bits (address bits above bit 7) equal 0x00 form the engine page. A write there pulses `eng_wr_en` in the same cycle, with `eng_addr` equal to address bits [7:0] and `eng_wr_data` equal to the write data. A read there returns `eng_rd_data`.
- R2: `reg_rd_valid` is high in exactly the cycle after a `reg_rd_req` cycle, and `reg_rd_data` holds the selected value in that cycle.
- R3: Local offset 0x1000 accepts the transmit length in 64-bit words. A read of 0x1000 returns the number of words written to the transmit FIFO so far.
- R4: A write to 0x1004 clears both word counts and the error flag, and loads the verify enable from bit 1. If bit 0 of the written value is 0, the write also starts transmission. A read of 0x1004 returns bit 0 = transmit busy, bit 1 = verify error and bit 2 = `conn_on`, with all other bits 0.
- R5: Writing 1 to bit 0 of 0x1008 stops transmission and clears both counts and the error flag. Bit 0 of 0x1008 always reads 0.
- R6: A cycle with `timer_irq` high sets a flag that reads back at bit 8 of 0x1008. The flag stays set until a write to 0x1008 with bit 8 = 1. Bit 16 of 0x1008 reads `link_up`.
- R7: A read of 0x100C returns `rx_ff_last_cnt` in bits [2:0], `rx_ff_rd_cnt` in bits [15:3] and `tx_ff_full` in bit 24, with all other bits 0.
- R8: While transmission is enabled, `tx_ff_wr_en` equals NOT `tx_ff_full`. The word written at count n carries lane k (bits [32k+31:32k]) equal to 2n+k. Transmission ends after the last word of the programmed length, so exactly that many words are written.
- R9: `rx_ff_rd_en` is NOT `rx_ff_empty`. The receive count at 0x1010 increments once for each word read, one cycle after the read.
- R10: With verify enabled, a received word that differs from the pattern for its receive index (same packing as R8) sets the error flag, and the flag stays set. With verify disabled, no mismatch sets the flag.
- R11: Reads of unassigned local offsets, and reads of any address outside both pages, return zero. Writes outside both pages change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_req | input | 1 | Register read request |
| reg_addr | input | 16 | Byte address |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data, valid with reg_rd_valid |
| reg_rd_valid | output | 1 | Read return strobe |
| eng_wr_en | output | 1 | Engine register write strobe |
| eng_addr | output | 8 | Engine register byte offset |
| eng_wr_data | output | 32 | Engine register write data |
| eng_rd_data | input | 32 | Engine register read data for eng_addr |
| conn_on | input | 1 | Connection-open status from engine |
| timer_irq | input | 1 | Engine timer interrupt |
| link_up | input | 1 | Ethernet link status |
| tx_ff_full | input | 1 | Transmit FIFO full |
| tx_ff_wr_en | output | 1 | Transmit FIFO write enable |
| tx_ff_wr_data | output | 64 | Transmit FIFO write data |
| rx_ff_empty | input | 1 | Receive FIFO empty |
| rx_ff_rd_en | output | 1 | Receive FIFO read enable |
| rx_ff_rd_data | input | 64 | Receive FIFO data, valid one cycle after read |
| rx_ff_rd_cnt | input | 13 | Receive FIFO word fill count |
| rx_ff_last_cnt | input | 3 | Receive FIFO byte remainder count |

## Verification
The hardest situation to create from the ports is a mismatch on one specific word of the receive stream. That word must arrive one cycle after its read, while the FIFO empty flag is toggling. The bench plays the FIFO itself: it presents each word in the cycle after the design raised its read enable, corrupts the word at one chosen index, and runs the same stream with verification on and then off. For transmission, several lengths are swept against different full-flag duty patterns. Each emitted word is checked against its index, and the final count and busy bit are checked after the stop.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
   localparam logic [7:0] OFS_TXLEN = 8'h00;
   localparam logic [7:0] OFS_CMD   = 8'h04;
   localparam logic [7:0] OFS_RST   = 8'h08;
   localparam logic [7:0] OFS_FFST  = 8'h0C;
   localparam logic [7:0] OFS_RXLEN = 8'h10;
   localparam int         LANE_W    = 32;
endpackage

// File: rtl/tpe_tx_gen.sv
module tpe_tx_gen #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop,
   input  logic              start,
   input  logic              clr_cnt,
   input  logic [CNT_W-1:0]  len,
   input  logic              ff_full,
   output logic              ff_wr_en,
   output logic [DATA_W-1:0] ff_wr_data,
   output logic [CNT_W-1:0]  cnt,
   output logic              busy
);
   import tpe_pkg::*;
   localparam int LANES = DATA_W / LANE_W;

   initial begin
      assert (DATA_W % LANE_W == 0 && LANES >= 1) else $error("DATA_W must be a multiple of 32");
      assert (CNT_W >= 2) else $error("CNT_W too small");
   end

   logic        en_q;
   logic [31:0] base;

   assign ff_wr_en = en_q & ~ff_full;
   assign busy     = en_q;
   assign base     = 32'(cnt) * 32'(LANES);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign ff_wr_data[k*LANE_W +: LANE_W] = base + 32'(k);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         cnt  <= '0;
      end else if (stop) begin
         en_q <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         en_q <= 1'b1;
         cnt  <= '0;
      end else if (clr_cnt) begin
         cnt  <= '0;
      end else if (ff_wr_en) begin
         cnt <= cnt + 1'b1;
         if (cnt + 1'b1 == len) en_q <= 1'b0;
      end
   end

   p_no_wr_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ff_full |-> !ff_wr_en);
   p_cnt_below_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !start && !stop && !clr_cnt && len != '0 && cnt < len) |=> (!en_q || cnt < len));
endmodule

// File: rtl/tpe_rx_chk.sv
module tpe_rx_chk #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              verify_en,
   input  logic              ff_empty,
   input  logic [DATA_W-1:0] ff_rd_data,
   output logic              ff_rd_en,
   output logic [CNT_W-1:0]  cnt,
   output logic              fail
);
   import tpe_pkg::*;
   localparam int LANES = DATA_W / LANE_W;

   initial begin
      assert (DATA_W % LANE_W == 0) else $error("DATA_W must be a multiple of 32");
   end

   logic              rd_q;
   logic [31:0]       base;
   logic [DATA_W-1:0] exp_word;

   assign ff_rd_en = ~ff_empty;
   assign base     = 32'(cnt) * 32'(LANES);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign exp_word[k*LANE_W +: LANE_W] = base + 32'(k);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         cnt  <= '0;
         fail <= 1'b0;
      end else begin
         rd_q <= ff_rd_en;
         if (clr) begin
            cnt  <= '0;
            fail <= 1'b0;
         end else if (rd_q) begin
            cnt <= cnt + 1'b1;
            if (verify_en && ff_rd_data != exp_word) fail <= 1'b1;
         end
      end
   end

   p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clr) |=> fail);
   p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_q && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tpe_regfile.sv
module tpe_regfile #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 64,
   parameter int          CNT_W     = 32,
   parameter int          RXCNT_W   = 13,
   parameter logic [7:0]  ENG_PAGE  = 8'h00,
   parameter logic [7:0]  LOC_PAGE  = 8'h10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic               reg_rd_req,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wr_data,
   output logic [31:0]        reg_rd_data,
   output logic               reg_rd_valid,
   output logic               eng_wr_en,
   output logic [7:0]         eng_addr,
   output logic [31:0]        eng_wr_data,
   input  logic [31:0]        eng_rd_data,
   input  logic               conn_on,
   input  logic               timer_irq,
   input  logic               link_up,
   input  logic               tx_ff_full,
   output logic               tx_ff_wr_en,
   output logic [DATA_W-1:0]  tx_ff_wr_data,
   input  logic               rx_ff_empty,
   output logic               rx_ff_rd_en,
   input  logic [DATA_W-1:0]  rx_ff_rd_data,
   input  logic [RXCNT_W-1:0] rx_ff_rd_cnt,
   input  logic [2:0]         rx_ff_last_cnt
);
   import tpe_pkg::*;
   localparam int PAGE_W = ADDR_W - 8;

   initial begin
      assert (ADDR_W > 8 && PAGE_W <= 24) else $error("ADDR_W out of range");
      assert (3 + RXCNT_W <= 24) else $error("RXCNT_W overlaps full flag");
   end

   logic [PAGE_W-1:0] page;
   logic [7:0]        ofs;
   logic              hit_eng, hit_loc, loc_wr;
   logic              wr_txlen, wr_cmd, wr_rst, soft_rst, tx_start;
   logic [CNT_W-1:0]  tx_len, tx_cnt, rx_cnt;
   logic              tx_busy, rx_fail, verify_en, tmr_flag;
   logic [31:0]       loc_rd, rd_mux;

   assign page     = reg_addr[ADDR_W-1:8];
   assign ofs      = reg_addr[7:0];
   assign hit_eng  = (page == PAGE_W'(ENG_PAGE));
   assign hit_loc  = (page == PAGE_W'(LOC_PAGE));
   assign loc_wr   = reg_wr_en & hit_loc;
   assign wr_txlen = loc_wr && (ofs == OFS_TXLEN);
   assign wr_cmd   = loc_wr && (ofs == OFS_CMD);
   assign wr_rst   = loc_wr && (ofs == OFS_RST);
   assign soft_rst = wr_rst & reg_wr_data[0];
   assign tx_start = wr_cmd & ~reg_wr_data[0];

   assign eng_wr_en   = reg_wr_en & hit_eng;
   assign eng_addr    = ofs;
   assign eng_wr_data = reg_wr_data;

   tpe_tx_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop       (soft_rst),
      .start      (tx_start),
      .clr_cnt    (wr_cmd),
      .len        (tx_len),
      .ff_full    (tx_ff_full),
      .ff_wr_en   (tx_ff_wr_en),
      .ff_wr_data (tx_ff_wr_data),
      .cnt        (tx_cnt),
      .busy       (tx_busy)
   );

   tpe_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (wr_cmd | soft_rst),
      .verify_en  (verify_en),
      .ff_empty   (rx_ff_empty),
      .ff_rd_data (rx_ff_rd_data),
      .ff_rd_en   (rx_ff_rd_en),
      .cnt        (rx_cnt),
      .fail       (rx_fail)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_len    <= '0;
         verify_en <= 1'b0;
         tmr_flag  <= 1'b0;
      end else begin
         if (wr_txlen) tx_len <= CNT_W'(reg_wr_data);
         if (wr_cmd)   verify_en <= reg_wr_data[1];
         if (timer_irq)                      tmr_flag <= 1'b1;
         else if (wr_rst && reg_wr_data[8])  tmr_flag <= 1'b0;
      end
   end

   always_comb begin
      loc_rd = '0;
      unique case (ofs)
         OFS_TXLEN: loc_rd = 32'(tx_cnt);
         OFS_CMD:   loc_rd = {29'b0, conn_on, rx_fail, tx_busy};
         OFS_RST: begin
            loc_rd[8]  = tmr_flag;
            loc_rd[16] = link_up;
         end
         OFS_FFST: begin
            loc_rd[2:0]           = rx_ff_last_cnt;
            loc_rd[3 +: RXCNT_W]  = rx_ff_rd_cnt;
            loc_rd[24]            = tx_ff_full;
         end
         OFS_RXLEN: loc_rd = 32'(rx_cnt);
         default:   loc_rd = '0;
      endcase
      if (hit_eng)      rd_mux = eng_rd_data;
      else if (hit_loc) rd_mux = loc_rd;
      else              rd_mux = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rd_valid <= 1'b0;
         reg_rd_data  <= '0;
      end else begin
         reg_rd_valid <= reg_rd_req;
         if (reg_rd_req) reg_rd_data <= rd_mux;
      end
   end

   p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_req |=> reg_rd_valid);
   p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_req |=> !reg_rd_valid);
   p_tmr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_flag && !(wr_rst && reg_wr_data[8])) |=> tmr_flag);
   p_eng_only_on_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      eng_wr_en |-> (reg_wr_en && reg_addr[ADDR_W-1:8] == PAGE_W'(ENG_PAGE)));
endmodule

// File: tb/test_tpe_regfile.sv
module test_tpe_regfile;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_rd_req = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] reg_rd_data;
   logic        reg_rd_valid;
   logic        eng_wr_en;
   logic [7:0]  eng_addr;
   logic [31:0] eng_wr_data, eng_rd_data;
   logic        conn_on = 1'b0, timer_irq = 1'b0, link_up = 1'b0;
   logic        tx_ff_full = 1'b0, tx_ff_wr_en;
   logic [63:0] tx_ff_wr_data;
   logic        rx_ff_empty = 1'b1, rx_ff_rd_en;
   logic [63:0] rx_ff_rd_data = '0;
   logic [12:0] rx_ff_rd_cnt = '0;
   logic [2:0]  rx_ff_last_cnt = '0;

   int n_chk = 0, n_bad = 0;
   logic [31:0] eng_mem [64];
   logic [31:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   tpe_regfile i_tpe_regfile (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req),
      .reg_addr(reg_addr), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
      .reg_rd_valid(reg_rd_valid), .eng_wr_en(eng_wr_en), .eng_addr(eng_addr),
      .eng_wr_data(eng_wr_data), .eng_rd_data(eng_rd_data), .conn_on(conn_on),
      .timer_irq(timer_irq), .link_up(link_up), .tx_ff_full(tx_ff_full),
      .tx_ff_wr_en(tx_ff_wr_en), .tx_ff_wr_data(tx_ff_wr_data),
      .rx_ff_empty(rx_ff_empty), .rx_ff_rd_en(rx_ff_rd_en),
      .rx_ff_rd_data(rx_ff_rd_data), .rx_ff_rd_cnt(rx_ff_rd_cnt),
      .rx_ff_last_cnt(rx_ff_last_cnt)
   );

   // engine register model
   initial for (int i = 0; i < 64; i++) eng_mem[i] = 32'hA500_0000 + 32'(i);
   always @(posedge clk) if (eng_wr_en) eng_mem[eng_addr[7:2]] <= eng_wr_data;
   assign eng_rd_data = eng_mem[eng_addr[7:2]];

   function automatic logic [63:0] patt(int n);
      return {32'(2*n + 1), 32'(2*n)};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [31:0] d);
      reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_rd_req = 1'b0;
      chk("R2 valid", 64'(reg_rd_valid), 64'd1);
      d = reg_rd_data;
   endtask

   task automatic tx_run(int len, int fp);
      int sent = 0;
      int cyc = 0;
      wr(16'h1000, 32'(len));
      wr(16'h1004, 32'h0);
      while (sent < len && cyc < 200) begin
         tx_ff_full = (fp == 0) ? 1'b0 : ((cyc % (fp + 1)) == 1);
         #1;
         chk("R8 wr_en", 64'(tx_ff_wr_en), 64'(!tx_ff_full));
         if (tx_ff_wr_en) chk("R8 data", tx_ff_wr_data, patt(sent));
         @(posedge clk);
         if (tx_ff_wr_en) sent++;
         @(negedge clk);
         cyc++;
      end
      tx_ff_full = 1'b0;
      #1;
      chk("R8 stop", 64'(tx_ff_wr_en), 64'd0);
      rd(16'h1000, rv); chk("R3 count", 64'(rv), 64'(len));
      rd(16'h1004, rv); chk("R4 idle", 64'(rv[0]), 64'd0);
   endtask

   task automatic rx_run(int n, int bad_idx, logic ver, logic exp_fail);
      int k = 0;
      logic pend = 1'b0;
      int pidx = 0;
      int cyc = 0;
      wr(16'h1004, {30'b0, ver, 1'b1});
      while ((k < n || pend) && cyc < 200) begin
         if (pend) rx_ff_rd_data = patt(pidx) ^ ((pidx == bad_idx) ? 64'h100_0000_0000 : 64'h0);
         rx_ff_empty = (k < n) ? ((cyc % 3) == 2) : 1'b1;
         #1;
         chk("R9 rd_en", 64'(rx_ff_rd_en), 64'(!rx_ff_empty));
         @(posedge clk);
         pend = !rx_ff_empty;
         pidx = k;
         if (!rx_ff_empty) k++;
         @(negedge clk);
         cyc++;
      end
      rx_ff_empty = 1'b1;
      rd(16'h1010, rv); chk("R9 count", 64'(rv), 64'(n));
      rd(16'h1004, rv); chk("R10 fail", 64'(rv[1]), 64'(exp_fail));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R2 reset", 64'(reg_rd_valid), 64'd0);
      chk("R8 reset", 64'(tx_ff_wr_en), 64'd0);
      rd(16'h1004, rv); chk("R4 reset", 64'(rv), 64'd0);
      rd(16'h1000, rv); chk("R3 reset", 64'(rv), 64'd0);
      // R2 valid drops after request
      chk("R2 idle", 64'(reg_rd_valid), 64'd1);
      @(negedge clk);
      chk("R2 idle", 64'(reg_rd_valid), 64'd0);

      // R1 engine page
      for (int i = 0; i < 8; i++) begin
         wr(16'(4*i), 32'h1234_0000 + 32'(i * 17));
         rd(16'(4*i), rv); chk("R1 engine", 64'(rv), 64'(32'h1234_0000 + 32'(i * 17)));
      end
      rd(16'h003C, rv); chk("R1 engine untouched", 64'(rv), 64'(32'hA500_000F));
      wr(16'h2008, 32'hDEAD_BEEF);
      rd(16'h0008, rv); chk("R11 foreign page write", 64'(rv), 64'(32'h1234_0022));
      rd(16'h2008, rv); chk("R11 foreign page read", 64'(rv), 64'd0);
      rd(16'h1014, rv); chk("R11 unmapped local", 64'(rv), 64'd0);
      rd(16'h1080, rv); chk("R11 unmapped local", 64'(rv), 64'd0);

      // R8/R3 sweep
      for (int len = 1; len <= 6; len++)
         for (int fp = 0; fp < 3; fp++) tx_run(len, fp);

      // R9/R10 sweep
      rx_run(8, 99, 1'b1, 1'b0);
      rx_run(8, 3, 1'b1, 1'b1);
      wr(16'h1004, 32'h1);
      rd(16'h1004, rv); chk("R4 clears fail", 64'(rv[1]), 64'd0);
      rd(16'h1010, rv); chk("R4 clears rx count", 64'(rv), 64'd0);
      rx_run(8, 3, 1'b0, 1'b0);
      rx_run(5, 0, 1'b1, 1'b1);

      // R5 soft reset mid-transfer
      tx_ff_full = 1'b1;
      wr(16'h1000, 32'd50);
      wr(16'h1004, 32'h0);
      rd(16'h1004, rv); chk("R4 busy", 64'(rv[0]), 64'd1);
      tx_ff_full = 1'b0;
      repeat (3) @(negedge clk);
      tx_ff_full = 1'b1;
      rd(16'h1000, rv); chk("R3 partial", 64'(rv), 64'd3);
      wr(16'h1008, 32'h1);
      tx_ff_full = 1'b0;
      #1;
      chk("R5 stopped", 64'(tx_ff_wr_en), 64'd0);
      rd(16'h1004, rv); chk("R5 busy clear", 64'(rv[0]), 64'd0);
      rd(16'h1000, rv); chk("R5 count clear", 64'(rv), 64'd0);
      rd(16'h1008, rv); chk("R5 bit0 reads 0", 64'(rv[0]), 64'd0);

      // R6 timer latch and link
      link_up = 1'b1;
      timer_irq = 1'b1;
      @(negedge clk);
      timer_irq = 1'b0;
      rd(16'h1008, rv); chk("R6 latched", 64'(rv), 64'h0001_0100);
      wr(16'h1008, 32'h0);
      rd(16'h1008, rv); chk("R6 held", 64'(rv), 64'h0001_0100);
      wr(16'h1008, 32'h100);
      rd(16'h1008, rv); chk("R6 cleared", 64'(rv), 64'h0001_0000);

      // R4 conn_on and R7 FIFO status
      conn_on = 1'b1;
      rd(16'h1004, rv); chk("R4 conn_on", 64'(rv), 64'h4);
      tx_ff_full = 1'b1;
      rx_ff_rd_cnt = 13'h1ABC;
      rx_ff_last_cnt = 3'd5;
      rd(16'h100C, rv); chk("R7 status", 64'(rv), 64'(32'h0100_0000 | (32'h1ABC << 3) | 32'd5));
      rx_ff_rd_cnt = 13'h0001;
      rx_ff_last_cnt = 3'd2;
      tx_ff_full = 1'b0;
      rd(16'h100C, rv); chk("R7 status", 64'(rv), 64'h0000_000A);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule